// File: doc/BRIEF.md
# Serial bit-oriented frame transmitter with chunked refill buffer

This block turns bytes written by a processor into a bit-oriented serial frame stream. Bytes go into a 128-entry buffer through a byte-wide write port. A command byte then tells the block to begin or continue a frame, to mark the final piece of a frame, or to reset the transmit side. The block adds the opening flag, inserts a zero after every five consecutive ones, computes and appends the 16-bit frame check sequence, and sends the closing flag. Between frames the line carries all-ones fill. One bit leaves per pulse of the bit-clock enable.

Frames longer than the buffer are sent in pieces. The processor first fills the buffer and issues a start command without the end mark. It then waits for the refill interrupt, which signals that at least half of the buffer is free. It loads up to 64 more bytes and repeats until the last piece, which it sends with the end mark. If the buffer runs dry before the end mark arrives, the frame is aborted with a run of ones and a sticky underrun flag is set.

Top module: `hdlc_tx_ctrl`

## Requirements
- R1: After the synchronous reset `tx_bit` is 1, `cmd_rdata` is 00h and `underrun` is 0. `xfr_irq` is 1 from the second clock after reset release.
- R2: `cmd_rdata` always returns the last byte written through `cmd_wr`.
- R3: While no frame is in progress, every bit sent on `tx_bit` is 1.
- R4: A frame is the flag 7Eh, then the data bytes, then the frame check sequence, then the flag 7Eh. Every byte is sent least significant bit first. The check sequence is CRC-16 with polynomial x^16+x^12+x^5+1, processed bit-reflected and preset to FFFFh. It is inverted and sent low bit first.
- R5: Inside data and check-sequence bits, a 0 is inserted after every five consecutive 1s. Flags are never stuffed.
- R6: The buffer holds 128 bytes. A byte written while it is full is dropped and never transmitted.
- R7: Command bits are: bit 2 start/continue, bit 1 end of frame, bit 0 transmitter reset. `xfr_irq` is raised when at least 64 entries are free and no end mark is pending. Any command write without bit 0 clears it on the next clock.
- R8: A frame can be sent in pieces: a start command without the end mark, followed by refills and a later end command. The result is one continuous frame with a single check sequence.
- R9: If the buffer empties inside a frame with no end mark pending, the block sends at least eight 1s, returns to idle fill and sets `underrun`. `underrun` rises only while `tx_bit` is 1.
- R10: A command with bit 0 set takes precedence over the other command bits. On the next clock it empties the buffer, drops the frame in progress, forces `tx_bit` to 1, sets `xfr_irq` and clears `underrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable; one line bit per pulse |
| fifo_wr | input | 1 | Write strobe for the transmit buffer |
| fifo_wdata | input | 8 | Byte to append to the transmit buffer |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 8 | Command byte (bit 2 start, bit 1 end, bit 0 reset) |
| cmd_rdata | output | 8 | Last command byte written |
| tx_bit | output | 1 | Serial line bit, updated on bit_en |
| xfr_irq | output | 1 | Refill request interrupt |
| underrun | output | 1 | Sticky flag: a frame was aborted because the buffer ran dry |

## Verification
The framer is driven with several byte patterns. A short frame mixes 01h, FFh and 7Eh, so stuffing, a flag value inside the data and check-sequence stuffing all occur; an error in the shift order or the stuff rule shows up as a bit-level mismatch. A 150-byte frame sent in two pieces tells a correct refill handshake and check sequence across pieces apart from one that restarts or corrupts the frame. A piece with no end mark exercises the abort path. A 130-byte burst into an empty buffer separates dropping on full from overwriting. A transmitter reset in the middle of a frame, followed by a fresh short frame, shows whether stale bytes survive the reset.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  localparam int CMD_RST_BIT = 0;
  localparam int CMD_END_BIT = 1;
  localparam int CMD_GO_BIT  = 2;

  localparam int          FLAG_W   = 8;
  localparam logic [7:0]  FLAG_PAT = 8'h7E;
  localparam int          FCS_W    = 16;
  localparam logic [15:0] FCS_POLY = 16'h8408; // bit-reflected x^16+x^12+x^5+1
  localparam int          STUFF_RUN = 5;
  localparam int          ABORT_ONES = 8;

  typedef enum logic [2:0] {
    TX_IDLE, TX_OPEN, TX_DATA, TX_FCS, TX_CLOSE, TX_ABORT
  } tx_state_e;

  function automatic logic [FCS_W-1:0] fcs_step(input logic [FCS_W-1:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? FCS_POLY : '0);
  endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DEPTH = 128,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       wr_en,
  input  logic [DW-1:0]              wr_data,
  input  logic                       rd_en,
  output logic [DW-1:0]              rd_data,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          wr_ok, rd_ok;

  assign wr_ok   = wr_en && (count != CW'(DEPTH));
  assign rd_ok   = rd_en && (count != '0);
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= (int'(wr_ptr) == DEPTH-1) ? '0 : wr_ptr + 1'b1;
      if (rd_ok) rd_ptr <= (int'(rd_ptr) == DEPTH-1) ? '0 : rd_ptr + 1'b1;
      if (wr_ok && !rd_ok)      count <= count + 1'b1;
      else if (!wr_ok && rd_ok) count <= count - 1'b1;
    end
  end

  // R6
  full_write_dropped_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && !clr && count == CW'(DEPTH)) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          bit_en,
  input  logic          active,
  input  logic          end_pend,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_data,
  output logic          pop,
  output logic          done,
  output logic          abort,
  output logic          tx_bit
);
  localparam int SW = FCS_W;
  localparam int CNTW = $clog2(SW);

  tx_state_e       st, nst;
  logic [SW-1:0]   sh, nsh;
  logic [CNTW-1:0] cnt, ncnt;
  logic [2:0]      ones, nones;
  logic [FCS_W-1:0] crc, ncrc, crc_n;
  logic            stuff, obit;

  always_comb begin
    stuff = (st inside {TX_DATA, TX_FCS, TX_CLOSE, TX_ABORT}) && (int'(ones) == STUFF_RUN);
    case (st)
      TX_IDLE:  obit = 1'b1;
      TX_ABORT: obit = !stuff;
      default:  obit = stuff ? 1'b0 : sh[0];
    endcase
    crc_n = fcs_step(crc, sh[0]);
    nst = st; nsh = sh; ncnt = cnt; nones = ones; ncrc = crc;
    pop = 1'b0; done = 1'b0; abort = 1'b0;
    if (bit_en) begin
      case (st)
        TX_IDLE: if (active && !fifo_empty) begin
          nst = TX_OPEN; nsh = SW'(FLAG_PAT); ncnt = '0; nones = '0; ncrc = '1;
        end
        TX_OPEN: begin
          nsh = sh >> 1; ncnt = cnt + 1'b1;
          if (int'(cnt) == FLAG_W-1) begin
            nst = TX_DATA; nsh = SW'(fifo_data); pop = 1'b1; ncnt = '0;
          end
        end
        TX_DATA: if (stuff) nones = '0;
        else begin
          ncrc = crc_n; nones = sh[0] ? ones + 3'd1 : 3'd0;
          nsh = sh >> 1; ncnt = cnt + 1'b1;
          if (int'(cnt) == DW-1) begin
            ncnt = '0;
            if (!fifo_empty) begin
              nsh = SW'(fifo_data); pop = 1'b1;
            end else if (end_pend) begin
              nst = TX_FCS; nsh = ~crc_n;
            end else nst = TX_ABORT;
          end
        end
        TX_FCS: if (stuff) nones = '0;
        else begin
          nones = sh[0] ? ones + 3'd1 : 3'd0;
          nsh = sh >> 1; ncnt = cnt + 1'b1;
          if (int'(cnt) == FCS_W-1) begin
            nst = TX_CLOSE; nsh = SW'(FLAG_PAT); ncnt = '0;
          end
        end
        TX_CLOSE: if (stuff) nones = '0;
        else begin
          nones = '0; nsh = sh >> 1; ncnt = cnt + 1'b1;
          if (int'(cnt) == FLAG_W-1) begin nst = TX_IDLE; done = 1'b1; end
        end
        TX_ABORT: if (stuff) nones = '0;
        else begin
          ncnt = cnt + 1'b1;
          if (int'(cnt) == ABORT_ONES-1) begin nst = TX_IDLE; abort = 1'b1; end
        end
        default: nst = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st <= TX_IDLE; sh <= '0; cnt <= '0; ones <= '0; crc <= '1; tx_bit <= 1'b1;
    end else begin
      st <= nst; sh <= nsh; cnt <= ncnt; ones <= nones; crc <= ncrc;
      if (bit_en) tx_bit <= obit;
    end
  end

  // R5
  stuffed_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !clr && st == TX_DATA && int'(ones) == STUFF_RUN) |=> !tx_bit);

  // R3
  idle_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_en && st == TX_IDLE) |=> tx_bit);

endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int CHUNK = 64,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          fifo_wr,
  input  logic [DW-1:0] fifo_wdata,
  input  logic          cmd_wr,
  input  logic [7:0]    cmd_wdata,
  output logic [7:0]    cmd_rdata,
  output logic          tx_bit,
  output logic          xfr_irq,
  output logic          underrun
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] REFILL_LVL = CW'(DEPTH - CHUNK);

  logic          cmd_rst, active, end_pend;
  logic          pop, done, abort;
  logic [DW-1:0] head;
  logic [CW-1:0] level;

  assign cmd_rst = cmd_wr && cmd_wdata[CMD_RST_BIT];

  hdlc_tx_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst(rst), .clr(cmd_rst),
    .wr_en(fifo_wr), .wr_data(fifo_wdata),
    .rd_en(pop), .rd_data(head), .count(level)
  );

  hdlc_tx_framer #(.DW(DW)) u_framer (
    .clk(clk), .rst(rst), .clr(cmd_rst), .bit_en(bit_en),
    .active(active), .end_pend(end_pend), .fifo_empty(level == '0),
    .fifo_data(head), .pop(pop), .done(done), .abort(abort), .tx_bit(tx_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_rdata <= '0; active <= 1'b0; end_pend <= 1'b0;
      xfr_irq <= 1'b0; underrun <= 1'b0;
    end else begin
      if (cmd_wr) cmd_rdata <= cmd_wdata;
      if (cmd_rst) begin
        active <= 1'b0; end_pend <= 1'b0; xfr_irq <= 1'b1; underrun <= 1'b0;
      end else begin
        if (done || abort) begin active <= 1'b0; end_pend <= 1'b0; end
        if (cmd_wr && cmd_wdata[CMD_GO_BIT])  active   <= 1'b1;
        if (cmd_wr && cmd_wdata[CMD_END_BIT]) end_pend <= 1'b1;
        if (abort) underrun <= 1'b1;
        if (cmd_wr) xfr_irq <= 1'b0;
        else if (level <= REFILL_LVL && !end_pend) xfr_irq <= 1'b1;
      end
    end
  end

  // R10
  reset_cmd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_rst |=> (tx_bit && xfr_irq && !underrun));

  // R7
  cmd_clears_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !cmd_wdata[CMD_RST_BIT]) |=> !xfr_irq);

  // R9
  underrun_on_ones_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> tx_bit);

endmodule

// File: tb/test_hdlc_tx_ctrl.sv
module test_hdlc_tx_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       fifo_wr = 1'b0;
  logic [7:0] fifo_wdata = '0;
  logic       cmd_wr = 1'b0;
  logic [7:0] cmd_wdata = '0;
  logic [7:0] cmd_rdata;
  logic       tx_bit, xfr_irq, underrun;

  hdlc_tx_ctrl i_hdlc_tx_ctrl (
    .clk(clk), .rst(rst), .bit_en(bit_en), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .tx_bit(tx_bit), .xfr_irq(xfr_irq), .underrun(underrun)
  );

  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit exp_q[$];
  logic [7:0] frame_buf[$];
  int  ones_m = 0;
  bit  synced = 0;
  bit  mon_on = 1;
  bit  finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void add_bit(input bit b, input bit stuff_on);
    exp_q.push_back(b);
    if (stuff_on) begin
      ones_m = b ? ones_m + 1 : 0;
      if (ones_m == 5) begin exp_q.push_back(1'b0); ones_m = 0; end
    end
  endfunction

  // Scoreboard driver: expected line bits for the bytes in frame_buf
  function automatic void push_frame(input bit with_end);
    logic [15:0] c = 16'hFFFF;
    logic [15:0] fcs;
    logic [7:0]  flag = 8'h7E;
    ones_m = 0;
    for (int i = 0; i < 8; i++) add_bit(flag[i], 1'b0);
    foreach (frame_buf[k]) begin
      for (int i = 0; i < 8; i++) begin
        add_bit(frame_buf[k][i], 1'b1);
        c = (c >> 1) ^ ((c[0] ^ frame_buf[k][i]) ? 16'h8408 : 16'h0000);
      end
    end
    if (with_end) begin
      fcs = ~c;
      for (int i = 0; i < 16; i++) add_bit(fcs[i], 1'b1);
      for (int i = 0; i < 8; i++) add_bit(flag[i], 1'b0);
    end else begin
      for (int i = 0; i < 8; i++) add_bit(1'b1, 1'b0);
    end
  endfunction

  task automatic put_bytes(input int from, input int to);
    for (int k = from; k < to; k++) begin
      @(negedge clk); fifo_wr = 1'b1; fifo_wdata = frame_buf[k];
    end
    @(negedge clk); fifo_wr = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] v);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = v;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic wait_drain;
    while (exp_q.size() != 0 || synced) @(posedge clk);
    repeat (40) @(posedge clk);
    @(negedge clk);
  endtask

  // bit-clock enable: one pulse every 4 clocks
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
    end
  end

  // Scoreboard monitor
  initial begin
    bit en, e;
    forever begin
      @(posedge clk);
      en = bit_en;
      #2;
      if (en && mon_on && !rst) begin
        if (!synced) begin
          if (exp_q.size() != 0 && tx_bit == 1'b0) synced = 1;
          else if (exp_q.size() == 0) check(tx_bit == 1'b1, "R3 idle fill", tx_bit, 1);
        end
        if (synced) begin
          e = exp_q.pop_front();
          check(tx_bit == e, "R4 R5 frame bit", tx_bit, e);
          if (exp_q.size() == 0) synced = 0;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got %0h expected %0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int hi_ok;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(tx_bit == 1'b1, "R1 tx_bit", tx_bit, 1);
    check(cmd_rdata == 8'h00, "R1 cmd_rdata", cmd_rdata, 0);
    check(underrun == 1'b0, "R1 underrun", underrun, 0);
    @(negedge clk);
    check(xfr_irq == 1'b1, "R1 R7 irq after reset", xfr_irq, 1);

    // Short frame with stuffing and flag pattern in data
    frame_buf = '{8'h01, 8'hFF, 8'h7E};
    push_frame(1'b1);
    put_bytes(0, 3);
    send_cmd(8'h06);
    check(xfr_irq == 1'b0, "R7 irq cleared by cmd", xfr_irq, 0);
    check(cmd_rdata == 8'h06, "R2 readback", cmd_rdata, 8'h06);
    wait_drain();
    check(xfr_irq == 1'b1, "R7 irq after frame", xfr_irq, 1);

    // R8 long frame in two pieces
    frame_buf.delete();
    for (int k = 0; k < 150; k++) frame_buf.push_back(8'((k * 37 + 5) ^ (k >> 2)));
    push_frame(1'b1);
    put_bytes(0, 128);
    send_cmd(8'h04);
    check(xfr_irq == 1'b0, "R7 R8 no irq with full buffer", xfr_irq, 0);
    while (!xfr_irq) @(negedge clk);
    check(exp_q.size() > 0, "R8 irq before frame end", exp_q.size(), 1);
    put_bytes(128, 150);
    send_cmd(8'h02);
    check(cmd_rdata == 8'h02, "R2 readback end", cmd_rdata, 8'h02);
    wait_drain();
    check(underrun == 1'b0, "R8 no underrun", underrun, 0);

    // R9 underrun abort
    frame_buf.delete();
    for (int k = 0; k < 10; k++) frame_buf.push_back(8'hF8 + 8'(k));
    push_frame(1'b0);
    put_bytes(0, 10);
    send_cmd(8'h04);
    wait_drain();
    check(underrun == 1'b1, "R9 underrun set", underrun, 1);
    check(tx_bit == 1'b1, "R9 idle after abort", tx_bit, 1);

    // R10 transmitter reset mid-frame
    mon_on = 0;
    frame_buf.delete();
    for (int k = 0; k < 40; k++) frame_buf.push_back(8'h00);
    put_bytes(0, 40);
    send_cmd(8'h06);
    repeat (200) @(negedge clk);
    send_cmd(8'h01);
    check(tx_bit == 1'b1, "R10 line forced to ones", tx_bit, 1);
    check(xfr_irq == 1'b1, "R10 irq set", xfr_irq, 1);
    check(underrun == 1'b0, "R10 underrun cleared", underrun, 0);
    check(cmd_rdata == 8'h01, "R2 readback reset", cmd_rdata, 8'h01);
    hi_ok = 1;
    repeat (400) begin @(negedge clk); if (!tx_bit) hi_ok = 0; end
    check(hi_ok == 1, "R10 frame dropped", hi_ok, 1);
    exp_q.delete(); synced = 0; mon_on = 1;

    // After reset: fresh frame must not contain stale bytes
    frame_buf = '{8'h3C, 8'hA5, 8'h1F, 8'hF0, 8'h55};
    push_frame(1'b1);
    put_bytes(0, 5);
    send_cmd(8'h06);
    wait_drain();

    // R6 writes beyond 128 entries dropped
    frame_buf.delete();
    for (int k = 0; k < 130; k++) frame_buf.push_back(8'(k * 3));
    put_bytes(0, 130);
    frame_buf = frame_buf[0:127];
    push_frame(1'b1);
    send_cmd(8'h06);
    wait_drain();
    check(exp_q.size() == 0, "R6 full buffer frame complete", exp_q.size(), 0);
    check(xfr_irq == 1'b1, "R7 irq after full frame", xfr_irq, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule